// File: doc/BRIEF.md
# Reset Sequencer with Cause Recording

This block collects every reset request of a processor core and turns them into one synchronous system reset. The inputs are a power-on event, an external active-low reset pin (recorded separately for normal run and for sleep), watchdog expiry, brown-out detection, a software reset command, a trap-conflict lockup and an illegal-operation fault. The external pin passes through a two-stage synchronizer and a glitch filter. The pin is only an input, so internal causes never drive it.

After a power-on event the sequencer holds reset for a fixed number of clock cycles. It then runs a power-up timer whose length comes from a 2-bit selector and is counted in 1 ms tick pulses. Other causes skip the fixed delay and start the power-up timer directly. Release waits for the next phase-1 strobe. In the first cycle out of reset the block gives a one-cycle pulse that forces the fetch address to the reset vector.

An eight-bit set of sticky flags records every cause seen, and software clears bits by writing a mask. A watchdog expiry during sleep counts as a wake-up: it resumes operation and neither resets nor records anything.

Top module: `rst_seq_top`

## Requirements
- R1: The flag bit positions are: bit 0 power-on, 1 pin reset in run, 2 pin reset in sleep, 3 watchdog, 4 brown-out, 5 software reset, 6 trap lockup, 7 illegal operation. Every non-power-on cause asserts `sys_rst` and sets its own bit.
- R2: While `por_evt` is high, `sys_rst` is 1 and `cause_flags` is 8'h01, with all other bits cleared.
- R3: After `por_evt` falls, reset is held for `POR_CYC` clock cycles before the power-up timer starts.
- R4: `pwrt_sel` values 0, 1, 2 and 3 select 0, 4, 16 and 64 `ms_tick` pulses of power-up delay.
- R5: `sys_rst` falls only in the cycle after `q1_edge` was sampled high. `vector_load` is high for exactly the first cycle with `sys_rst` low.
- R6: A synchronized low on `pin_n` lasting fewer than 4 consecutive cycles is ignored. A low lasting 4 or more cycles causes a pin reset.
- R7: A pin reset sets bit 2 when `in_sleep` is high and bit 1 otherwise.
- R8: `wdt_expire` while `in_sleep` is high causes no reset and sets no flag.
- R9: `bor_det` causes a reset only while `bor_en` is high.
- R10: Flags are sticky. With `clr_we` high, each bit set in `clr_mask` is cleared. A cause arriving in the same cycle wins over the clear.
- R11: A new request while reset is held restarts the delay from its start.
- R12: Non-power-on causes skip the fixed `POR_CYC` delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_evt | input | 1 | Power-on event, active high, asynchronous |
| pin_n | input | 1 | External reset pin, active low, asynchronous |
| in_sleep | input | 1 | Core is in sleep |
| wdt_expire | input | 1 | Watchdog expiry |
| bor_det | input | 1 | Brown-out detected |
| bor_en | input | 1 | Brown-out reset enable |
| sw_rst | input | 1 | Software reset command |
| trap_lock | input | 1 | Trap-conflict lockup |
| illegal_op | input | 1 | Illegal opcode or uninitialized pointer use |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| q1_edge | input | 1 | Phase-1 leading-edge strobe |
| pwrt_sel | input | 2 | Power-up timer selector |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 8 | Bits to clear |
| sys_rst | output | 1 | System reset, active high |
| vector_load | output | 1 | Reset-vector fetch pulse |
| cause_flags | output | 8 | Sticky cause flags |

## Verification
The assertions assume that a power-on event opens every run, so no property is evaluated on state from before the first `por_evt`. They also assume that `pwrt_sel` stays steady while a delay is counting. The stimulus starts with `por_evt` high and changes the selector only while the design is out of reset, just before it issues a request. Tick and phase-1 strobes come from free-running bench counters as single-cycle pulses, which matches the pulse form the timer counts.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NCAUSE  = 8;
  localparam int MS_W    = 7;
  localparam int C_POR   = 0;
  localparam int C_PINR  = 1;
  localparam int C_PINS  = 2;
  localparam int C_WDT   = 3;
  localparam int C_BOR   = 4;
  localparam int C_SWR   = 5;
  localparam int C_TRAP  = 6;
  localparam int C_ILL   = 7;

  typedef enum logic [1:0] {ST_POR, ST_PWRT, ST_ALIGN, ST_RUN} seq_state_t;

  // power-up timer length in ms ticks for a selector value
  function automatic logic [MS_W-1:0] pwrt_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return MS_W'(0);
      2'd1:    return MS_W'(4);
      2'd2:    return MS_W'(16);
      default: return MS_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC = 2,
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic por_evt,
  input  logic pin_n,
  output logic pin_req
);
  localparam int CW = $clog2(FILT + 1);

  logic [SYNC-1:0] sy;
  logic [CW-1:0]   cnt;
  logic            sync_low;

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) sy <= '1;
    else         sy <= {sy[SYNC-2:0], pin_n};
  end

  assign sync_low = !sy[SYNC-1];

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt)                  cnt <= '0;
    else if (!sync_low)           cnt <= '0;
    else if (cnt != CW'(FILT))    cnt <= cnt + 1'b1;
  end

  assign pin_req = (cnt == CW'(FILT));

  // R6: an accepted pin request needs a run of synchronized low samples
  assert_filter_run_R6: assert property (@(posedge clk) disable iff (por_evt)
    pin_req |-> ($past(sync_low) && $past(sync_low, 2)));
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              por_evt,
  input  logic [NCAUSE-1:0] set_vec,
  input  logic              clr_we,
  input  logic [NCAUSE-1:0] clr_mask,
  output logic [NCAUSE-1:0] flags
);
  for (genvar g = 0; g < NCAUSE; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or posedge por_evt) begin
      if (por_evt) q <= 1'(g == C_POR);
      else         q <= set_vec[g] | (q & !(clr_we & clr_mask[g]));
    end
    assign flags[g] = q;
  end

  // R10: without a clear strobe no flag ever drops
  assert_sticky_R10: assert property (@(posedge clk) disable iff (por_evt)
    !$past(clr_we) |-> ((flags & $past(flags)) == $past(flags)));

  // R10: a cause in the clear cycle still shows afterwards
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (por_evt)
    (clr_we && (set_vec != '0)) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/rst_delay_timer.sv
module rst_delay_timer
  import rst_seq_pkg::*;
#(
  parameter int POR_CYC = 500
) (
  input  logic       clk,
  input  logic       por_evt,
  input  logic       restart,
  input  logic       ms_tick,
  input  logic       q1_edge,
  input  logic [1:0] pwrt_sel,
  output logic       sys_rst,
  output logic       vector_load
);
  localparam int PW = $clog2(POR_CYC + 1);

  seq_state_t      st;
  logic [PW-1:0]   pc;
  logic [MS_W-1:0] mc;
  logic [MS_W-1:0] target;
  logic            por_done;
  logic            pwrt_done;
  logic            release_ev;

  assign target     = pwrt_ms(pwrt_sel);
  assign por_done   = (st == ST_POR) && (pc == PW'(POR_CYC - 1));
  assign pwrt_done  = (st == ST_PWRT) && (mc == target);
  assign release_ev = (st == ST_ALIGN) && q1_edge && !restart;

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) begin
      st          <= ST_POR;
      pc          <= '0;
      mc          <= '0;
      vector_load <= 1'b0;
    end else begin
      vector_load <= 1'b0;
      if (restart) begin
        if (st == ST_POR) pc <= '0;
        else begin
          st <= ST_PWRT;
          mc <= '0;
        end
      end else begin
        case (st)
          ST_POR: begin
            if (por_done) begin
              st <= ST_PWRT;
              mc <= '0;
            end else pc <= pc + 1'b1;
          end
          ST_PWRT: begin
            if (pwrt_done)    st <= ST_ALIGN;
            else if (ms_tick) mc <= mc + 1'b1;
          end
          ST_ALIGN: begin
            if (release_ev) begin
              st          <= ST_RUN;
              vector_load <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sys_rst = (st != ST_RUN);

  // R5: release follows a sampled phase-1 strobe
  assert_release_q1_R5: assert property (@(posedge clk) disable iff (por_evt)
    $fell(sys_rst) |-> $past(q1_edge));

  // R5: vector pulse marks exactly the first released cycle
  assert_vector_pulse_R5: assert property (@(posedge clk) disable iff (por_evt)
    vector_load |-> (!sys_rst && $past(sys_rst)));

  // R4: the ms counter only advances on a tick
  assert_tick_only_R4: assert property (@(posedge clk) disable iff (por_evt)
    ((st == ST_PWRT) && ($past(st) == ST_PWRT) && !$past(restart) && !$past(ms_tick))
      |-> $stable(mc));

  // R3: the power-up timer is entered from the fixed delay only after it ran out
  assert_por_first_R3: assert property (@(posedge clk) disable iff (por_evt)
    ((st == ST_PWRT) && ($past(st) == ST_POR)) |-> $past(por_done));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_CYC = 500,
  parameter int SYNC    = 2,
  parameter int FILT    = 4
) (
  input  logic              clk,
  input  logic              por_evt,
  input  logic              pin_n,
  input  logic              in_sleep,
  input  logic              wdt_expire,
  input  logic              bor_det,
  input  logic              bor_en,
  input  logic              sw_rst,
  input  logic              trap_lock,
  input  logic              illegal_op,
  input  logic              ms_tick,
  input  logic              q1_edge,
  input  logic [1:0]        pwrt_sel,
  input  logic              clr_we,
  input  logic [NCAUSE-1:0] clr_mask,
  output logic              sys_rst,
  output logic              vector_load,
  output logic [NCAUSE-1:0] cause_flags
);
  logic              pin_req;
  logic [NCAUSE-1:0] req;
  logic              any_req;

  rst_pin_filter #(.SYNC(SYNC), .FILT(FILT)) i_filt (
    .clk(clk), .por_evt(por_evt), .pin_n(pin_n), .pin_req(pin_req)
  );

  always_comb begin
    req          = '0;
    req[C_PINR]  = pin_req & !in_sleep;
    req[C_PINS]  = pin_req & in_sleep;
    req[C_WDT]   = wdt_expire & !in_sleep;
    req[C_BOR]   = bor_det & bor_en;
    req[C_SWR]   = sw_rst;
    req[C_TRAP]  = trap_lock;
    req[C_ILL]   = illegal_op;
  end

  assign any_req = |req;

  rst_delay_timer #(.POR_CYC(POR_CYC)) i_tmr (
    .clk(clk), .por_evt(por_evt), .restart(any_req), .ms_tick(ms_tick),
    .q1_edge(q1_edge), .pwrt_sel(pwrt_sel), .sys_rst(sys_rst),
    .vector_load(vector_load)
  );

  rst_cause_flags i_flags (
    .clk(clk), .por_evt(por_evt), .set_vec(req), .clr_we(clr_we),
    .clr_mask(clr_mask), .flags(cause_flags)
  );

  // R8: once released, reset stays off without a qualifying request
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (por_evt)
    (!sys_rst && !any_req) |=> !sys_rst);

  // R9: brown-out flag can rise only with the enable high
  assert_bor_gate_R9: assert property (@(posedge clk) disable iff (por_evt)
    $rose(cause_flags[C_BOR]) |-> $past(bor_en && bor_det));

  // R1: any qualifying request holds the core in reset next cycle
  assert_req_resets_R1: assert property (@(posedge clk) disable iff (por_evt)
    any_req |=> sys_rst);
endmodule

// File: tb/test_rst_seq_top.sv
module test_rst_seq_top;
  localparam int POR = 500;
  localparam int TK  = 8;
  localparam int Q1  = 4;

  logic clk = 1'b0;
  logic por_evt = 1'b1, pin_n = 1'b1, in_sleep = 1'b0, wdt_expire = 1'b0;
  logic bor_det = 1'b0, bor_en = 1'b0, sw_rst = 1'b0, trap_lock = 1'b0;
  logic illegal_op = 1'b0, ms_tick = 1'b0, q1_edge = 1'b0, clr_we = 1'b0;
  logic [1:0] pwrt_sel = 2'd0;
  logic [7:0] clr_mask = 8'h00;
  logic sys_rst, vector_load;
  logic [7:0] cause_flags;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] exp_fl;

  always #10 clk = ~clk;

  rst_seq_top #(.POR_CYC(POR)) i_rst_seq_top (
    .clk(clk), .por_evt(por_evt), .pin_n(pin_n), .in_sleep(in_sleep),
    .wdt_expire(wdt_expire), .bor_det(bor_det), .bor_en(bor_en),
    .sw_rst(sw_rst), .trap_lock(trap_lock), .illegal_op(illegal_op),
    .ms_tick(ms_tick), .q1_edge(q1_edge), .pwrt_sel(pwrt_sel),
    .clr_we(clr_we), .clr_mask(clr_mask), .sys_rst(sys_rst),
    .vector_load(vector_load), .cause_flags(cause_flags)
  );

  // free-running strobes driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    ms_tick <= (cyc % TK) == 0;
    q1_edge <= (cyc % Q1) == 1;
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
    finish_run();
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=[%0d..%0d]", tag, act, lo, hi);
    end
  endtask

  function automatic int sel_ms(input int s);
    return (s == 0) ? 0 : (1 << (2 * s));
  endfunction

  function automatic int lat_lo(input int s, input bit por);
    int m = sel_ms(s);
    return (por ? POR : 0) + ((m > 0) ? (m - 1) * TK : 0);
  endfunction

  function automatic int lat_hi(input int s, input bit por);
    return (por ? POR : 0) + sel_ms(s) * TK + TK + Q1 + 10;
  endfunction

  // counts negedges until reset drops, checks the vector pulse
  task automatic wait_rel(input string tag, output int n);
    n = 0;
    while (sys_rst && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " vector pulse R5"}, vector_load, 1);
    @(negedge clk);
    chk({tag, " vector single R5"}, vector_load, 0);
  endtask

  task automatic pulse(input int c);
    @(negedge clk);
    case (c)
      3: wdt_expire = 1'b1;
      4: bor_det = 1'b1;
      5: sw_rst = 1'b1;
      6: trap_lock = 1'b1;
      default: illegal_op = 1'b1;
    endcase
    @(negedge clk);
    wdt_expire = 1'b0; bor_det = 1'b0; sw_rst = 1'b0;
    trap_lock = 1'b0; illegal_op = 1'b0;
  endtask

  task automatic pin_low(input int n);
    @(negedge clk);
    pin_n = 1'b0;
    repeat (n) @(negedge clk);
    pin_n = 1'b1;
  endtask

  task automatic do_por(input int s, input string tag);
    int n;
    @(negedge clk);
    pwrt_sel = 2'(s);
    por_evt = 1'b1;
    @(negedge clk);
    chk({tag, " rst during por R2"}, sys_rst, 1);
    chk({tag, " flags during por R2"}, cause_flags, 8'h01);
    por_evt = 1'b0;
    wait_rel(tag, n);
    chk_rng({tag, " por latency R3 R4"}, n, lat_lo(s, 1), lat_hi(s, 1));
    exp_fl = 8'h01;
  endtask

  // applies cause c (1..7) and checks release timing and flags
  task automatic cause(input int c, input int s, input string tag);
    int n, extra;
    @(negedge clk);
    pwrt_sel = 2'(s);
    extra = 0;
    if (c == 1 || c == 2) begin
      in_sleep = (c == 2);
      pin_low(8);
      extra = 6;
    end else begin
      bor_en = (c == 4);
      pulse(c);
    end
    chk({tag, " reset held R1"}, sys_rst, 1);
    wait_rel(tag, n);
    in_sleep = 1'b0;
    exp_fl = exp_fl | 8'(1 << c);
    chk_rng({tag, " latency R4 R12"}, n, lat_lo(s, 0), lat_hi(s, 0) + extra);
    chk({tag, " flags R1 R7"}, cause_flags, exp_fl);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    exp_fl = 8'h01;
    repeat (3) @(negedge clk);
    chk("reset state R2", sys_rst, 1);
    chk("reset flags R2", cause_flags, 8'h01);
    por_evt = 1'b0;
    wait_rel("first por", n);
    chk_rng("first por latency R3", n, lat_lo(0, 1), lat_hi(0, 1));

    for (int s = 1; s < 4; s++) do_por(s, "por sel");

    // R6: short glitch ignored
    pwrt_sel = 2'd0;
    pin_low(3);
    repeat (10) @(negedge clk);
    chk("short pin R6 rst", sys_rst, 0);
    chk("short pin R6 flags", cause_flags, exp_fl);

    cause(1, 0, "pin run R7");
    cause(2, 1, "pin sleep R7");

    // R8: watchdog during sleep is a wake-up
    in_sleep = 1'b1;
    pulse(3);
    repeat (8) @(negedge clk);
    in_sleep = 1'b0;
    chk("wdt sleep R8 rst", sys_rst, 0);
    chk("wdt sleep R8 flags", cause_flags, exp_fl);
    cause(3, 0, "wdt run R1");

    // R9: gated brown-out
    bor_en = 1'b0;
    @(negedge clk); bor_det = 1'b1;
    @(negedge clk); bor_det = 1'b0;
    repeat (6) @(negedge clk);
    chk("bor off R9 rst", sys_rst, 0);
    chk("bor off R9 flags", cause_flags, exp_fl);
    cause(4, 0, "bor on R9");
    bor_en = 1'b0;
    cause(5, 0, "sw R1");
    cause(6, 2, "trap R1");
    cause(7, 0, "illegal R1");
    chk("sticky all R10", cause_flags, 8'hFF);

    // R10: clear by mask
    @(negedge clk); clr_we = 1'b1; clr_mask = 8'hA5;
    @(negedge clk); clr_we = 1'b0; clr_mask = 8'h00;
    exp_fl = 8'h5A;
    chk("clear mask R10", cause_flags, exp_fl);

    // R10: set wins over clear in the same cycle
    @(negedge clk); clr_we = 1'b1; clr_mask = 8'hFF; sw_rst = 1'b1;
    @(negedge clk); clr_we = 1'b0; clr_mask = 8'h00; sw_rst = 1'b0;
    exp_fl = 8'h20;
    chk("set wins R10", cause_flags, exp_fl);
    wait_rel("set wins", n);

    // R11: restart during a long timer
    pwrt_sel = 2'd3;
    pulse(5);
    repeat (300) @(negedge clk);
    chk("long hold R11", sys_rst, 1);
    pulse(6);
    wait_rel("restart", n);
    chk_rng("restart latency R11", n, lat_lo(3, 0), lat_hi(3, 0));
    exp_fl = exp_fl | 8'h60;
    chk("restart flags R11", cause_flags, exp_fl);

    // R2: power-on drops the other flags
    do_por(0, "por clears");
    chk("por clears R2", cause_flags, 8'h01);

    // constrained random causes
    for (int i = 0; i < 20; i++) begin
      int c = 1 + int'($urandom % 7);
      int s = int'($urandom % 4);
      cause(c, s, "random R1");
      if (($urandom % 3) == 0) begin
        logic [7:0] m = 8'($urandom);
        @(negedge clk); clr_we = 1'b1; clr_mask = m;
        @(negedge clk); clr_we = 1'b0; clr_mask = 8'h00;
        exp_fl = exp_fl & ~m;
        chk("random clear R10", cause_flags, exp_fl);
      end
    end
    finish_run();
  end
endmodule